// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers reset requests from five internal sources (watchdog overflow, illegal opcode, unmapped-address opcode fetch, low supply voltage and a monitor-mode entry request), qualifies each one against its configuration and CPU-state inputs, and turns any accepted request into a timed system reset. While the reset is in progress it asserts an enable that pulls the external reset pin low. It also holds the CPU in reset, and it releases the two in order: the pin first, the CPU a short guard interval later.

All logic runs on a free-running reference clock. A request that is accepted in a clock cycle starts, or restarts, the hold counter. A low-voltage indication is a level, so it keeps the counter at its start value until the condition clears. The cause of each reset is recorded in a five-bit sticky status register. Software reads that register and clears it with a read strobe.

Top module: `rstseq`

## Requirements
- R1: A watchdog overflow pulse starts a reset and sets status bit 0 only when `wdog_dis` is 0. When `wdog_dis` is 1 the pulse leaves the pin, the CPU reset and the status unchanged.
- R2: While `test_volt` is 1, a watchdog overflow has no effect on the pin, the CPU reset or the status.
- R3: An illegal-opcode pulse starts a reset and sets status bit 1.
- R4: A STOP execution pulse is treated as an illegal opcode (reset, status bit 1) when `stop_en` is 0, and has no effect when `stop_en` is 1.
- R5: An unmapped-address pulse starts a reset and sets status bit 2 only when `fetch_opcode` is 1. An unmapped data access has no effect.
- R6: A low-voltage level starts a reset and sets status bit 3 only when both `lv_pwrd` and `lv_rstd` are 0.
- R7: After the last cycle in which an accepted request is sampled, `pin_low` stays 1 for exactly HOLD_CYC+GUARD_CYC cycles (default 4128), and `cpu_rst` stays 1 for a further GUARD_CYC cycles (default 32) before both are 0. For a low-voltage reset this count starts after the low-voltage condition clears.
- R8: A monitor-mode entry pulse starts a reset that drives the pin low and sets status bit 4.
- R9: `pin_low` is registered and rises on the clock edge that samples an accepted request. `cpu_rst` is 1 whenever `pin_low` is 1.
- R10: A request accepted while a sequence runs restarts the full hold count and ORs its cause bit into the status.
- R11: A request accepted while no sequence runs writes its own cause bit and clears all other status bits.
- R12: A `stat_rd` pulse clears the status register on the next clock edge.
- R13: After `rst` the outputs `pin_low`, `cpu_rst` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wdog_ovf | input | 1 | Watchdog overflow pulse |
| wdog_dis | input | 1 | Configuration: watchdog reset disabled |
| test_volt | input | 1 | Monitor/break test-voltage qualifier, blocks watchdog |
| ilop_det | input | 1 | Illegal opcode detected by decode |
| stop_exec | input | 1 | STOP instruction executed |
| stop_en | input | 1 | Configuration: STOP instruction allowed |
| ilad_det | input | 1 | Access to an unmapped address |
| fetch_opcode | input | 1 | Current access is an opcode fetch |
| lv_det | input | 1 | Low-voltage condition present (level) |
| lv_pwrd | input | 1 | Configuration: low-voltage detector powered down |
| lv_rstd | input | 1 | Configuration: low-voltage reset disabled |
| mon_req | input | 1 | Monitor-mode entry reset request |
| stat_rd | input | 1 | Status register read strobe (clears status) |
| pin_low | output | 1 | Enable for pulling the reset pin low |
| cpu_rst | output | 1 | CPU held in reset |
| status | output | 5 | Sticky cause bits: 0 watchdog, 1 illegal opcode, 2 illegal address, 3 low voltage, 4 monitor entry |

## Verification
If the phase or the hold counter is wrong, the result shows up at `pin_low` and `cpu_rst`. They are asserted for the wrong number of cycles, or they drop in the wrong order. The error becomes visible only thousands of cycles after the request, when the pin should be released, so every sequence is measured edge by edge until it ends. A qualification error or a status merge error is visible one edge after the request, as an extra or missing bit in `status`, or as a reset that starts when it should not. The tests therefore read the status on the cycle after each stimulus, and they also read it after stimuli that must be ignored.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NUM_CAUSE = 5;

    // bit 0 watchdog, 1 illegal opcode, 2 illegal address, 3 low voltage, 4 monitor
    typedef struct packed {
        logic mon;
        logic lowv;
        logic badaddr;
        logic badop;
        logic wdog;
    } cause_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PIN  = 2'd1,
        PH_CPU  = 2'd2
    } phase_t;

    function automatic logic cause_any(input cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/rstseq_qual.sv
module rstseq_qual
    import rstseq_pkg::*;
(
    input  logic   wdog_ovf,
    input  logic   wdog_dis,
    input  logic   test_volt,
    input  logic   ilop_det,
    input  logic   stop_exec,
    input  logic   stop_en,
    input  logic   ilad_det,
    input  logic   fetch_opcode,
    input  logic   lv_det,
    input  logic   lv_pwrd,
    input  logic   lv_rstd,
    input  logic   mon_req,
    output cause_t cause
);

    always_comb begin
        cause         = '0;
        cause.wdog    = wdog_ovf && !wdog_dis && !test_volt;
        cause.badop   = ilop_det || (stop_exec && !stop_en);
        cause.badaddr = ilad_det && fetch_opcode;
        cause.lowv    = lv_det && !lv_pwrd && !lv_rstd;
        cause.mon     = mon_req;
    end

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYC  = 4096,
    parameter int GUARD_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pin_low,
    output logic cpu_rst,
    output logic idle
);

    localparam int PIN_LEN = HOLD_CYC + GUARD_CYC;
    localparam int CW      = $clog2(PIN_LEN + 1);
    localparam logic [CW-1:0] PIN_LAST   = CW'(PIN_LEN - 1);
    localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYC - 1);

    phase_t          phase;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_PIN;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_PIN: begin
                    if (cnt == PIN_LAST) begin
                        phase <= PH_CPU;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CPU: begin
                    if (cnt == GUARD_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign pin_low = (phase == PH_PIN);
    assign cpu_rst = (phase != PH_IDLE);
    assign idle    = (phase == PH_IDLE);

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t cause,
    input  logic   idle,
    input  logic   rd,
    output cause_t flags
);

    logic   fresh;
    cause_t base;

    assign fresh = rd || (idle && cause_any(cause));
    assign base  = fresh ? cause_t'('0) : flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= base | cause;
        end
    end

endmodule

// File: rtl/rstseq.sv
module rstseq
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYC  = 4096,
    parameter int GUARD_CYC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wdog_ovf,
    input  logic                 wdog_dis,
    input  logic                 test_volt,
    input  logic                 ilop_det,
    input  logic                 stop_exec,
    input  logic                 stop_en,
    input  logic                 ilad_det,
    input  logic                 fetch_opcode,
    input  logic                 lv_det,
    input  logic                 lv_pwrd,
    input  logic                 lv_rstd,
    input  logic                 mon_req,
    input  logic                 stat_rd,
    output logic                 pin_low,
    output logic                 cpu_rst,
    output logic [NUM_CAUSE-1:0] status
);

    cause_t cause;
    cause_t flags;
    logic   idle;

    rstseq_qual u_qual (
        .wdog_ovf     (wdog_ovf),
        .wdog_dis     (wdog_dis),
        .test_volt    (test_volt),
        .ilop_det     (ilop_det),
        .stop_exec    (stop_exec),
        .stop_en      (stop_en),
        .ilad_det     (ilad_det),
        .fetch_opcode (fetch_opcode),
        .lv_det       (lv_det),
        .lv_pwrd      (lv_pwrd),
        .lv_rstd      (lv_rstd),
        .mon_req      (mon_req),
        .cause        (cause)
    );

    rstseq_timer #(
        .HOLD_CYC  (HOLD_CYC),
        .GUARD_CYC (GUARD_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (cause_any(cause)),
        .pin_low (pin_low),
        .cpu_rst (cpu_rst),
        .idle    (idle)
    );

    rstseq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .cause (cause),
        .idle  (idle),
        .rd    (stat_rd),
        .flags (flags)
    );

    assign status = flags;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int HOLD_CYC  = 4096,
    parameter int GUARD_CYC = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       wdog_ovf,
    input logic       wdog_dis,
    input logic       test_volt,
    input logic       ilop_det,
    input logic       stop_exec,
    input logic       stop_en,
    input logic       ilad_det,
    input logic       fetch_opcode,
    input logic       lv_det,
    input logic       lv_pwrd,
    input logic       lv_rstd,
    input logic       mon_req,
    input logic       pin_low,
    input logic       cpu_rst,
    input logic [4:0] status
);

    logic others_quiet;
    logic [31:0] tail_run;

    assign others_quiet = !ilop_det && !(stop_exec && !stop_en) &&
                          !(ilad_det && fetch_opcode) &&
                          !(lv_det && !lv_pwrd && !lv_rstd) && !mon_req;

    always_ff @(posedge clk) begin
        if (rst || !cpu_rst || pin_low) tail_run <= '0;
        else                            tail_run <= tail_run + 1;
    end

    AST_WDOG_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wdog_ovf && !wdog_dis && !test_volt) |=> (pin_low && status[0])); // R1

    AST_WDOG_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wdog_ovf && (wdog_dis || test_volt) && !cpu_rst && others_quiet) |=> !cpu_rst); // R2

    AST_BADOP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ilop_det || (stop_exec && !stop_en)) |=> (pin_low && status[1])); // R4

    AST_BADADDR_FETCH: assert property (@(posedge clk) disable iff (rst)
        (ilad_det && fetch_opcode) |=> (pin_low && status[2])); // R5

    AST_LOWV_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (lv_det && !lv_pwrd && !lv_rstd) |=> (pin_low && status[3])); // R6

    AST_MON_TAKEN: assert property (@(posedge clk) disable iff (rst)
        mon_req |=> (pin_low && status[4])); // R8

    AST_CPU_COVERS_PIN: assert property (@(posedge clk) disable iff (rst)
        pin_low |-> cpu_rst); // R9

    AST_PIN_FIRST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_low) |-> cpu_rst); // R7

    AST_GUARD_LEN: assert property (@(posedge clk) disable iff (rst)
        tail_run <= 32'(GUARD_CYC)); // R7

endmodule

bind rstseq rstseq_chk #(
    .HOLD_CYC  (HOLD_CYC),
    .GUARD_CYC (GUARD_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wdog_ovf     (wdog_ovf),
    .wdog_dis     (wdog_dis),
    .test_volt    (test_volt),
    .ilop_det     (ilop_det),
    .stop_exec    (stop_exec),
    .stop_en      (stop_en),
    .ilad_det     (ilad_det),
    .fetch_opcode (fetch_opcode),
    .lv_det       (lv_det),
    .lv_pwrd      (lv_pwrd),
    .lv_rstd      (lv_rstd),
    .mon_req      (mon_req),
    .pin_low      (pin_low),
    .cpu_rst      (cpu_rst),
    .status       (status)
);

// File: tb/rstseq_tb_top.sv
module rstseq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4096;
    localparam int GUARD      = 32;
    localparam int PIN_LEN    = HOLD + GUARD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wdog_ovf = 0, wdog_dis = 0, test_volt = 0, ilop_det = 0;
    logic stop_exec = 0, stop_en = 1, ilad_det = 0, fetch_opcode = 0;
    logic lv_det = 0, lv_pwrd = 0, lv_rstd = 0, mon_req = 0, stat_rd = 0;
    logic pin_low, cpu_rst;
    logic [4:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstseq #(.HOLD_CYC(HOLD), .GUARD_CYC(GUARD)) dut_i (
        .clk(clk), .rst(rst), .wdog_ovf(wdog_ovf), .wdog_dis(wdog_dis),
        .test_volt(test_volt), .ilop_det(ilop_det), .stop_exec(stop_exec),
        .stop_en(stop_en), .ilad_det(ilad_det), .fetch_opcode(fetch_opcode),
        .lv_det(lv_det), .lv_pwrd(lv_pwrd), .lv_rstd(lv_rstd),
        .mon_req(mon_req), .stat_rd(stat_rd), .pin_low(pin_low),
        .cpu_rst(cpu_rst), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // at a negedge: count cycles with pin low, then cpu-only cycles
    task automatic measure(output int pin_n, output int tail_n);
        pin_n = 0; tail_n = 0;
        while (pin_low && pin_n < PIN_LEN + 10) begin pin_n++; @(negedge clk); end
        while (cpu_rst && tail_n < GUARD + 10) begin tail_n++; @(negedge clk); end
    endtask

    task automatic full_seq(input string req);
        int p, t;
        measure(p, t);
        check({req, " pin hold"}, p, PIN_LEN);
        check({req, " cpu tail"}, t, GUARD);
        check({req, " cpu released"}, int'(cpu_rst), 0);
    endtask

    task automatic read_clear();
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        check("R12 status cleared", int'(status), 0);
    endtask

    task automatic expect_ignored(input string req, input int prev);
        repeat (3) @(negedge clk);
        check({req, " pin idle"}, int'(pin_low), 0);
        check({req, " cpu idle"}, int'(cpu_rst), 0);
        check({req, " status kept"}, int'(status), prev);
    endtask

    task automatic t_reset();
        check("R13 pin", int'(pin_low), 0);
        check("R13 cpu", int'(cpu_rst), 0);
        check("R13 status", int'(status), 0);
    endtask

    task automatic t_wdog();
        wdog_ovf = 1; @(negedge clk); wdog_ovf = 0;
        check("R9 pin rises after sampling edge", int'(pin_low), 1);
        check("R9 cpu with pin", int'(cpu_rst), 1);
        check("R1 status wdog", int'(status), 5'b00001);
        full_seq("R7 wdog");
    endtask

    task automatic t_wdog_blocked();
        int prev = int'(status);
        wdog_dis = 1; wdog_ovf = 1; @(negedge clk); wdog_ovf = 0; wdog_dis = 0;
        expect_ignored("R1 disabled", prev);
        test_volt = 1; wdog_ovf = 1; @(negedge clk); wdog_ovf = 0; test_volt = 0;
        expect_ignored("R2 test voltage", prev);
    endtask

    task automatic t_badop();
        // status still holds watchdog bit: fresh cause must clear it
        ilop_det = 1; @(negedge clk); ilop_det = 0;
        check("R3 R11 status only ilop", int'(status), 5'b00010);
        full_seq("R3");
        read_clear();
    endtask

    task automatic t_stop();
        stop_en = 0; stop_exec = 1; @(negedge clk); stop_exec = 0;
        check("R4 stop as illegal", int'(status), 5'b00010);
        full_seq("R4");
        read_clear();
        stop_en = 1; stop_exec = 1; @(negedge clk); stop_exec = 0;
        expect_ignored("R4 stop allowed", 0);
    endtask

    task automatic t_badaddr();
        fetch_opcode = 0; ilad_det = 1; @(negedge clk); ilad_det = 0;
        expect_ignored("R5 data access", 0);
        fetch_opcode = 1; ilad_det = 1; @(negedge clk); ilad_det = 0; fetch_opcode = 0;
        check("R5 status ilad", int'(status), 5'b00100);
        full_seq("R5");
        read_clear();
    endtask

    task automatic t_lowv();
        lv_pwrd = 1; lv_det = 1; @(negedge clk); lv_det = 0; lv_pwrd = 0;
        expect_ignored("R6 powered down", 0);
        lv_rstd = 1; lv_det = 1; @(negedge clk); lv_det = 0; lv_rstd = 0;
        expect_ignored("R6 reset disabled", 0);
        lv_det = 1;
        repeat (200) @(negedge clk);
        check("R6 status lowv", int'(status), 5'b01000);
        check("R6 pin during level", int'(pin_low), 1);
        lv_det = 0;
        full_seq("R7 lowv after clear");
        read_clear();
    endtask

    task automatic t_mon();
        mon_req = 1; @(negedge clk); mon_req = 0;
        check("R8 pin low", int'(pin_low), 1);
        check("R8 status mon", int'(status), 5'b10000);
        full_seq("R8");
        read_clear();
    endtask

    task automatic t_restart();
        wdog_ovf = 1; @(negedge clk); wdog_ovf = 0;
        repeat (1000) @(negedge clk);
        ilop_det = 1; @(negedge clk); ilop_det = 0;
        check("R10 status OR", int'(status), 5'b00011);
        full_seq("R10 restart");
        read_clear();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_wdog();
        t_wdog_blocked();
        t_badop();
        t_stop();
        t_badaddr();
        t_lowv();
        t_mon();
        t_restart();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule